// File: doc/BRIEF.md
# Transmit Equalizer Coefficient Update Responder

This block sits on the local transmit side of backplane link training. Each cycle it takes a 16-bit coefficient request word from the link partner. That word asks for each of three transmit FIR taps (pre-cursor, main, post-cursor) to be held, stepped up or stepped down. It can also force all three taps to a defined start setting or to a flat setting with equalization switched off. The block keeps the three tap values and answers with a 16-bit status word. For each tap, the status word reports whether the last request was carried out or was refused at a limit. It also carries a local receiver-ready flag.

A tap moves only on the opening edge of a request, when its field changes from hold to a step. The result stays posted until the partner returns the field to hold, and the status field then clears. When training is switched off, the received word no longer reaches the taps. A host write port then loads the request word instead, so the taps can be driven by hand.

Top module: `lt_coef_responder`

## Requirements
- R1: While `rst_ni` is low and after release, the taps hold their parameter start values (defaults: pre 2, main 40, post 4), all status bits are 0 and `upd_word_o` is 0.
- R2: Request bits [1:0] drive the pre tap, [3:2] the main tap and [5:4] the post tap, each coded 00 hold, 01 step up, 10 step down. A field that changes from hold to a step code moves its tap by exactly one, and the status field at the same position reads 10 (updated). Fields act independently within one word.
- R3: While a step code stays unchanged, the tap does not move again and the status field keeps its value. Once the field returns to hold, the status field reads 00.
- R4: A step-up request on a tap already at its upper limit (defaults: pre 7, main 47, post 15) leaves the tap unchanged and reports 11 in its status field.
- R5: A step-down request on a tap already at its lower limit (defaults: pre 0, main 16, post 0) leaves the tap unchanged and reports 01 in its status field.
- R6: The request code 11 behaves exactly like hold: no tap movement and a status field of 00. A later change from 11 to a step code counts as an opening edge.
- R7: Bit 12 of the request word loads all taps with their start values and clears the status fields to 00.
- R8: Bit 13 of the request word loads the main tap with its flat value (default 47) and both side taps with 0, and clears the status fields. It wins when bit 12 is also set.
- R9: Status bit 15 shows `rx_ready_i` with the same delay as the tap fields. Status bits 14:6 are 0.
- R10: While `train_en_i` is high, the request word is taken from `rx_upd_i` every cycle and `host_we_i` is ignored. While it is low, `rx_upd_i` is ignored, a cycle with `host_we_i` high loads `host_upd_i`, and otherwise the word is kept.
- R11: `upd_word_o` shows the taken request word one clock after it is presented. Taps and status follow two clocks after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_en_i | input | 1 | Training enable; selects the partner word or the host word |
| rx_upd_i | input | 16 | Request word received from the link partner |
| rx_ready_i | input | 1 | Local receiver reports training complete |
| host_we_i | input | 1 | Host write strobe for the request word |
| host_upd_i | input | 16 | Host-supplied request word |
| upd_word_o | output | 16 | Request word currently in effect |
| pre_tap_o | output | 5 | Pre-cursor tap value |
| main_tap_o | output | 6 | Main tap value |
| post_tap_o | output | 5 | Post-cursor tap value |
| status_o | output | 16 | Status report word |

## Verification
A request presented after clock edge p appears on `upd_word_o` after edge p+1. The taps, the three status fields and the ready bit appear after edge p+2. The driver task computes both results from the requirements when it presents a word and queues them with due edges p+1 and p+2. The monitor compares on the falling edge, so words sent back to back are checked in the cycle each result is due. A queued item that is overdue counts as a mismatch.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int WORD_W     = 16;
  localparam int INIT_BIT   = 12;
  localparam int PRESET_BIT = 13;
  localparam int READY_BIT  = 15;
  localparam int NUM_TAPS   = 3;

  typedef enum logic [1:0] {
    REQ_HOLD = 2'b00,
    REQ_INC  = 2'b01,
    REQ_DEC  = 2'b10,
    REQ_RSVD = 2'b11
  } req_e;

  typedef enum logic [1:0] {
    STS_NONE = 2'b00,
    STS_MIN  = 2'b01,
    STS_UPD  = 2'b10,
    STS_MAX  = 2'b11
  } sts_e;

  // reserved code folds onto hold
  function automatic req_e req_decode(input logic [1:0] f);
    return (f == 2'b11) ? REQ_HOLD : req_e'(f);
  endfunction
endpackage

// File: rtl/lt_upd_src.sv
module lt_upd_src
  import lt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              train_en_i,
  input  logic [WORD_W-1:0] rx_upd_i,
  input  logic              rx_ready_i,
  input  logic              host_we_i,
  input  logic [WORD_W-1:0] host_upd_i,
  output logic [WORD_W-1:0] upd_o,
  output logic              ready_o
);
  logic [WORD_W-1:0] upd_q;
  logic              rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rx_ready_i;
      if (train_en_i)     upd_q <= rx_upd_i;
      else if (host_we_i) upd_q <= host_upd_i;
    end
  end

  assign upd_o   = upd_q;
  assign ready_o = rdy_q;

  a_r10_rx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_en_i |=> (upd_q == $past(rx_upd_i)));
  a_r10_host_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!train_en_i && host_we_i) |=> (upd_q == $past(host_upd_i)));
  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!train_en_i && !host_we_i) |=> $stable(upd_q));
endmodule

// File: rtl/lt_tap_unit.sv
module lt_tap_unit
  import lt_pkg::*;
#(
  parameter int W        = 5,
  parameter int MIN_V    = 0,
  parameter int MAX_V    = 15,
  parameter int INIT_V   = 4,
  parameter int PRESET_V = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   req_i,
  input  logic         init_i,
  input  logic         preset_i,
  output logic [W-1:0] tap_o,
  output logic [1:0]   sts_o
);
  localparam logic [W-1:0] LO  = W'(MIN_V);
  localparam logic [W-1:0] HI  = W'(MAX_V);
  localparam logic [W-1:0] INI = W'(INIT_V);
  localparam logic [W-1:0] FLT = W'(PRESET_V);

  req_e         req_c, prev_q;
  sts_e         sts_q;
  logic [W-1:0] tap_q;
  logic         step;
  logic         force_c;

  assign req_c   = req_decode(req_i);
  assign step    = (prev_q == REQ_HOLD) && (req_c != REQ_HOLD);
  assign force_c = init_i || preset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q  <= INI;
      sts_q  <= STS_NONE;
      prev_q <= REQ_HOLD;
    end else begin
      prev_q <= req_c;
      if (preset_i) begin
        tap_q <= FLT;
        sts_q <= STS_NONE;
      end else if (init_i) begin
        tap_q <= INI;
        sts_q <= STS_NONE;
      end else if (step) begin
        if (req_c == REQ_INC) begin
          if (tap_q >= HI) sts_q <= STS_MAX;
          else begin
            tap_q <= tap_q + 1'b1;
            sts_q <= STS_UPD;
          end
        end else begin
          if (tap_q <= LO) sts_q <= STS_MIN;
          else begin
            tap_q <= tap_q - 1'b1;
            sts_q <= STS_UPD;
          end
        end
      end else if (req_c == REQ_HOLD) begin
        sts_q <= STS_NONE;
      end
    end
  end

  assign tap_o = tap_q;
  assign sts_o = sts_q;

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_c |=> (tap_q == $past(tap_q) || tap_q == W'($past(tap_q) + 1'b1)
                  || tap_q == W'($past(tap_q) - 1'b1)));
  a_r3_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_c && !step) |=> $stable(tap_q));
  a_r3_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_c && req_c == REQ_HOLD) |=> (sts_q == STS_NONE));
  a_r4_max_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_c && step && req_c == REQ_INC && tap_q == HI)
      |=> (sts_q == STS_MAX && $stable(tap_q)));
  a_r5_min_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_c && step && req_c == REQ_DEC && tap_q == LO)
      |=> (sts_q == STS_MIN && $stable(tap_q)));
  a_r7_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !preset_i) |=> (tap_q == INI && sts_q == STS_NONE));
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_q >= LO && tap_q <= HI));
endmodule

// File: rtl/lt_coef_responder.sv
module lt_coef_responder
  import lt_pkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int PRE_MIN     = 0,
  parameter int PRE_MAX     = 7,
  parameter int PRE_INIT    = 2,
  parameter int MAIN_W      = 6,
  parameter int MAIN_MIN    = 16,
  parameter int MAIN_MAX    = 47,
  parameter int MAIN_INIT   = 40,
  parameter int MAIN_PRESET = 47,
  parameter int POST_W      = 5,
  parameter int POST_MIN    = 0,
  parameter int POST_MAX    = 15,
  parameter int POST_INIT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              train_en_i,
  input  logic [WORD_W-1:0] rx_upd_i,
  input  logic              rx_ready_i,
  input  logic              host_we_i,
  input  logic [WORD_W-1:0] host_upd_i,
  output logic [WORD_W-1:0] upd_word_o,
  output logic [PRE_W-1:0]  pre_tap_o,
  output logic [MAIN_W-1:0] main_tap_o,
  output logic [POST_W-1:0] post_tap_o,
  output logic [WORD_W-1:0] status_o
);
  localparam int STS_W = 2 * NUM_TAPS;
  localparam int PAD_W = READY_BIT - STS_W;

  logic [WORD_W-1:0] upd_q;
  logic              rdy_s1, rdy_q;
  logic [1:0]        pre_sts, main_sts, post_sts;
  logic              init_c, preset_c;

  lt_upd_src u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .train_en_i(train_en_i),
    .rx_upd_i  (rx_upd_i),
    .rx_ready_i(rx_ready_i),
    .host_we_i (host_we_i),
    .host_upd_i(host_upd_i),
    .upd_o     (upd_q),
    .ready_o   (rdy_s1)
  );

  assign init_c   = upd_q[INIT_BIT];
  assign preset_c = upd_q[PRESET_BIT];

  lt_tap_unit #(.W(PRE_W), .MIN_V(PRE_MIN), .MAX_V(PRE_MAX),
                .INIT_V(PRE_INIT), .PRESET_V(0)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(upd_q[1:0]),
    .init_i(init_c), .preset_i(preset_c),
    .tap_o(pre_tap_o), .sts_o(pre_sts));

  lt_tap_unit #(.W(MAIN_W), .MIN_V(MAIN_MIN), .MAX_V(MAIN_MAX),
                .INIT_V(MAIN_INIT), .PRESET_V(MAIN_PRESET)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(upd_q[3:2]),
    .init_i(init_c), .preset_i(preset_c),
    .tap_o(main_tap_o), .sts_o(main_sts));

  lt_tap_unit #(.W(POST_W), .MIN_V(POST_MIN), .MAX_V(POST_MAX),
                .INIT_V(POST_INIT), .PRESET_V(0)) u_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(upd_q[5:4]),
    .init_i(init_c), .preset_i(preset_c),
    .tap_o(post_tap_o), .sts_o(post_sts));

  // second stage aligns ready with the tap results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rdy_s1;
  end

  assign upd_word_o = upd_q;
  assign status_o   = {rdy_q, {PAD_W{1'b0}}, post_sts, main_sts, pre_sts};

  a_r8_preset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_c |=> (pre_tap_o == '0 && post_tap_o == '0
                  && main_tap_o == MAIN_W'(MAIN_PRESET) && status_o[STS_W-1:0] == '0));
  a_r9_ready_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o[READY_BIT] == $past(rdy_s1)));
endmodule

// File: tb/lt_coef_responder_test.sv
`timescale 1ns/1ps
module lt_coef_responder_test;
  localparam int PRE_MIN = 0,  PRE_MAX = 7,  PRE_INIT = 2;
  localparam int MAIN_MIN = 16, MAIN_MAX = 47, MAIN_INIT = 40, MAIN_FLAT = 47;
  localparam int POST_MIN = 0, POST_MAX = 15, POST_INIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_en = 1'b1;
  logic [15:0] rx_upd = '0;
  logic        rx_ready = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_upd = '0;
  logic [15:0] upd_word;
  logic [4:0]  pre_tap;
  logic [5:0]  main_tap;
  logic [4:0]  post_tap;
  logic [15:0] status;

  always #5 clk = ~clk;

  lt_coef_responder #(
    .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX), .PRE_INIT(PRE_INIT),
    .MAIN_MIN(MAIN_MIN), .MAIN_MAX(MAIN_MAX), .MAIN_INIT(MAIN_INIT), .MAIN_PRESET(MAIN_FLAT),
    .POST_MIN(POST_MIN), .POST_MAX(POST_MAX), .POST_INIT(POST_INIT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .train_en_i(train_en), .rx_upd_i(rx_upd),
    .rx_ready_i(rx_ready), .host_we_i(host_we), .host_upd_i(host_upd),
    .upd_word_o(upd_word), .pre_tap_o(pre_tap), .main_tap_o(main_tap),
    .post_tap_o(post_tap), .status_o(status)
  );

  typedef struct {
    int          due;
    bit          is_word;
    logic [15:0] word;
    int          pre, mn, post;
    logic [15:0] sts;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0, edge_cnt = 0;
  bit done = 0;

  // reference state
  int          m_tap[3];
  int          m_prev[3];
  int          m_sts[3];
  logic [15:0] m_word = '0;
  int          lo[3], hi[3], ini[3], flt[3];

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic model_apply(input logic [15:0] w, input logic rdy, output logic [15:0] sts);
    for (int i = 0; i < 3; i++) begin
      int r;
      r = w[2*i +: 2];
      if (r == 3) r = 0;                // R6
      if (w[13]) begin m_tap[i] = flt[i]; m_sts[i] = 0; end        // R8
      else if (w[12]) begin m_tap[i] = ini[i]; m_sts[i] = 0; end   // R7
      else if (m_prev[i] == 0 && r != 0) begin
        if (r == 1) begin
          if (m_tap[i] >= hi[i]) m_sts[i] = 3;                     // R4
          else begin m_tap[i]++; m_sts[i] = 2; end
        end else begin
          if (m_tap[i] <= lo[i]) m_sts[i] = 1;                     // R5
          else begin m_tap[i]--; m_sts[i] = 2; end
        end
      end else if (r == 0) m_sts[i] = 0;                           // R3
      m_prev[i] = r;
    end
    sts = {rdy, 9'b0, 2'(m_sts[2]), 2'(m_sts[1]), 2'(m_sts[0])};
  endtask

  task automatic send(input logic [15:0] w, input logic rdy, input logic ten,
                      input logic hwe, input logic [15:0] hw, input string tag);
    exp_t e;
    logic [15:0] s;
    @(posedge clk);
    #2;
    rx_upd = w; rx_ready = rdy; train_en = ten; host_we = hwe; host_upd = hw;
    if (ten) m_word = w;
    else if (hwe) m_word = hw;
    e.due = edge_cnt + 1; e.is_word = 1; e.word = m_word; e.tag = "R11";
    e.pre = 0; e.mn = 0; e.post = 0; e.sts = '0;
    q.push_back(e);
    model_apply(m_word, rdy, s);
    e.due = edge_cnt + 2; e.is_word = 0; e.tag = tag;
    e.pre = m_tap[0]; e.mn = m_tap[1]; e.post = m_tap[2]; e.sts = s;
    q.push_back(e);
  endtask

  task automatic rx(input logic [15:0] w, input string tag);
    send(w, rx_ready, 1'b1, 1'b0, 16'h0, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= edge_cnt) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (e.due < edge_cnt) begin
        n_bad++;
        $display("FAIL %s: result overdue at edge %0d (due %0d)", e.tag, edge_cnt, e.due);
      end else if (e.is_word) begin
        if (upd_word !== e.word) begin
          n_bad++;
          $display("FAIL %s: upd_word got %h exp %h", e.tag, upd_word, e.word);
        end
      end else if (pre_tap !== 5'(e.pre) || main_tap !== 6'(e.mn) ||
                   post_tap !== 5'(e.post) || status !== e.sts) begin
        n_bad++;
        $display("FAIL %s: taps/sts got %0d %0d %0d %h exp %0d %0d %0d %h", e.tag,
                 pre_tap, main_tap, post_tap, status, e.pre, e.mn, e.post, e.sts);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    lo  = '{PRE_MIN, MAIN_MIN, POST_MIN};
    hi  = '{PRE_MAX, MAIN_MAX, POST_MAX};
    ini = '{PRE_INIT, MAIN_INIT, POST_INIT};
    flt = '{0, MAIN_FLAT, 0};
    for (int i = 0; i < 3; i++) begin m_tap[i] = ini[i]; m_prev[i] = 0; m_sts[i] = 0; end

    repeat (3) @(negedge clk);
    // R1: under reset
    n_cmp++;
    if (pre_tap !== 5'(PRE_INIT) || main_tap !== 6'(MAIN_INIT) || post_tap !== 5'(POST_INIT)
        || status !== 16'h0 || upd_word !== 16'h0) begin
      n_bad++;
      $display("FAIL R1: reset got %0d %0d %0d %h %h exp %0d %0d %0d 0000 0000",
               pre_tap, main_tap, post_tap, status, upd_word, PRE_INIT, MAIN_INIT, POST_INIT);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_cmp++;
    if (pre_tap !== 5'(PRE_INIT) || status !== 16'h0) begin
      n_bad++;
      $display("FAIL R1: after release got %0d %h exp %0d 0000", pre_tap, status, PRE_INIT);
    end

    rx(16'h0001, "R2");   // pre up
    rx(16'h0000, "R3");
    rx(16'h0018, "R2");   // post up, main down
    rx(16'h0018, "R3");   // held: no second step
    rx(16'h0018, "R3");
    rx(16'h0000, "R3");
    rx(16'h0003, "R6");   // reserved on pre
    rx(16'h003F, "R6");   // reserved everywhere
    rx(16'h0001, "R6");   // reserved -> up is an opening edge
    rx(16'h0000, "R3");

    for (int k = 0; k < 12; k++) begin   // main up to ceiling and beyond
      rx(16'h0004, "R4");
      rx(16'h0000, "R4");
    end
    rx(16'h0004, "R4");
    rx(16'h0004, "R4");
    rx(16'h0000, "R4");

    for (int k = 0; k < 7; k++) begin    // pre down to floor and beyond
      rx(16'h0002, "R5");
      rx(16'h0000, "R5");
    end

    rx(16'h0002, "R5");
    rx(16'h1002, "R7");   // init overrides request
    rx(16'h0000, "R7");
    rx(16'h2000, "R8");
    rx(16'h0000, "R8");
    rx(16'h1000, "R7");
    rx(16'h3000, "R8");   // both: flat wins
    rx(16'h0000, "R8");
    rx(16'h1000, "R7");
    rx(16'h0000, "R7");

    send(16'h0000, 1'b1, 1'b1, 1'b0, 16'h0, "R9");
    send(16'h0010, 1'b1, 1'b1, 1'b0, 16'h0, "R9");
    send(16'h0000, 1'b0, 1'b1, 1'b0, 16'h0, "R9");

    // R10: host write ignored while training
    send(16'h0000, 1'b0, 1'b1, 1'b1, 16'h0001, "R10");
    // training off: received word ignored
    send(16'h0001, 1'b0, 1'b0, 1'b0, 16'h0000, "R10");
    send(16'h0004, 1'b0, 1'b0, 1'b0, 16'h0000, "R10");
    send(16'h0001, 1'b0, 1'b0, 1'b1, 16'h0008, "R10");
    send(16'h0001, 1'b0, 1'b0, 1'b0, 16'h0000, "R10");
    send(16'h0001, 1'b0, 1'b0, 1'b1, 16'h0000, "R10");
    send(16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, "R10");

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: %0d results never compared, exp 0", q.size());
    end
    done = 1;
    finish_run();
  end
endmodule